// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by fetching translation entries from memory. It uses one read port that returns one word per request. Each walk begins at the top-level table, whose base address the caller supplies on a root-base input. The walker reads one directory entry. If that entry maps a 4 MB region, the walk ends after that single read. Otherwise the entry points at a second-level table, and a second read fetches the entry for a 4 KB page. A directory entry maps a large region only when its page-size flag is set and the large-page enable input is high.

The walker reports two kinds of fault. An entry with its present bit clear gives a not-present fault. A write request that lands on a leaf entry marked read-only gives a write-protect fault. Each fault also reports the level at which it occurred. The walker handles one request at a time. The result appears for a single cycle, after which the walker is ready for the next request.

Top module: `pgwalk_top`

## Requirements
- R1: Out of reset the walker is idle: req_ready is 1, while mem_rd_valid and done_valid are 0.
- R2: The first read of every walk is at root_base + 4 × va[31:22]. root_base is sampled when the request is accepted.
- R3: If the directory entry maps a second-level table, the second read is at {pde[31:12], 12'h000} + 4 × va[21:12]. A successful result then gives done_paddr = {pte[31:12], va[11:0]} and done_large = 0.
- R4: With large_en = 1, a present directory entry with bit 7 set ends the walk after one read. The result gives done_paddr = {pde[31:22], va[21:0]} and done_large = 1.
- R5: With large_en = 0, bit 7 of a directory entry has no effect. The walk always takes the two-level path, and done_large = 0.
- R6: An entry with bit 0 (present) clear ends the walk with done_fault = 1, done_fault_kind = 0 and no further read. done_fault_level is 0 for a directory entry and 1 for a table entry.
- R7: A write request (req_write = 1) whose leaf entry has bit 1 (writable) clear ends with done_fault = 1 and done_fault_kind = 1, at the leaf's level. The same mapping read without a write request completes normally.
- R8: The walker waits any number of cycles for mem_rd_ack. It holds mem_rd_valid and mem_rd_addr steady until the acknowledge arrives.
- R9: A request is taken only while req_ready = 1 (idle). A request presented during a walk is ignored and does not change that walk's reads or result.
- R10: done_valid is high for exactly one cycle per walk. In the following cycle req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| root_base | input | 32 | Byte address of the top-level table |
| large_en | input | 1 | Enables 4 MB mappings from directory entries |
| req_valid | input | 1 | Translation request |
| req_addr | input | 32 | Linear address to translate |
| req_write | input | 1 | Request is for a write access |
| req_ready | output | 1 | Walker idle, request taken this cycle if valid |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rd_ack | input | 1 | Read data valid this cycle |
| mem_rd_data | input | 32 | Entry returned by memory |
| done_valid | output | 1 | Walk result valid, one cycle |
| done_paddr | output | 32 | Translated physical address (0 on fault) |
| done_fault | output | 1 | Walk ended in a fault |
| done_fault_kind | output | 1 | 0 not present, 1 write protect |
| done_fault_level | output | 1 | 0 directory, 1 table |
| done_large | output | 1 | Result came from a 4 MB mapping |

## Verification
The checker assumes that memory raises mem_rd_ack only while a read is outstanding, and only for one cycle per read. It also assumes that root_base and large_en are meaningful at the moment a request is accepted. The bench memory model answers only pending reads, after a programmable latency, and drops the acknowledge after one cycle. The bench keeps the control inputs steady for the whole of each walk, which keeps the stimulus within these assumptions. Entries that are absent from the model read back as zero, so an unmapped address produces a not-present fault rather than an undefined result.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

   typedef enum logic [2:0] {
      WS_IDLE  = 3'd0,
      WS_DIR   = 3'd1,
      WS_TBL   = 3'd2,
      WS_DONE  = 3'd3,
      WS_FAULT = 3'd4
   } walk_state_e;

   localparam logic FK_ABSENT  = 1'b0;
   localparam logic FK_PROTECT = 1'b1;
   localparam logic LVL_DIR    = 1'b0;
   localparam logic LVL_TBL    = 1'b1;

endpackage

// File: rtl/pgwalk_pte_dec.sv
module pgwalk_pte_dec #(
   parameter int ENTRY_W       = 32,
   parameter int FRAME_LSB     = 12,
   parameter int HUGE_LSB      = 22,
   parameter int VALID_BIT     = 0,
   parameter int WRITE_BIT     = 1,
   parameter int SIZE_BIT      = 7,
   parameter bit LARGE_SUPPORT = 1'b1
) (
   input  logic [ENTRY_W-1:0] entry,
   input  logic               large_en,
   input  logic               is_write,
   output logic               present,
   output logic               write_denied,
   output logic               huge,
   output logic [ENTRY_W-1:0] small_base,
   output logic [ENTRY_W-1:0] huge_base
);

   logic unused_attr;
   assign unused_attr = ^entry;

   assign present      = entry[VALID_BIT];
   assign write_denied = is_write & ~entry[WRITE_BIT];
   assign small_base   = {entry[ENTRY_W-1:FRAME_LSB], {FRAME_LSB{1'b0}}};
   assign huge_base    = {entry[ENTRY_W-1:HUGE_LSB], {HUGE_LSB{1'b0}}};

   generate
      if (LARGE_SUPPORT) begin : g_large
         assign huge = large_en & entry[SIZE_BIT];
      end else begin : g_small_only
         logic unused_en;
         assign unused_en = large_en;
         assign huge      = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/pgwalk_addr.sv
module pgwalk_addr #(
   parameter int ADDR_W = 32,
   parameter int OFFS_W = 12,
   parameter int IDX_W  = 10
) (
   input  logic              sel_tbl,
   input  logic [ADDR_W-1:0] root,
   input  logic [ADDR_W-1:0] tbl_base,
   input  logic [ADDR_W-1:0] va,
   output logic [ADDR_W-1:0] rd_addr
);

   localparam int DIR_LSB = OFFS_W + IDX_W;
   localparam int PAD_W   = ADDR_W - IDX_W - 2;

   logic [ADDR_W-1:0] dir_off;
   logic [ADDR_W-1:0] tbl_off;
   logic              unused_low;

   assign unused_low = ^va[OFFS_W-1:0];
   assign dir_off    = {{PAD_W{1'b0}}, va[ADDR_W-1:DIR_LSB], 2'b00};
   assign tbl_off    = {{PAD_W{1'b0}}, va[DIR_LSB-1:OFFS_W], 2'b00};
   assign rd_addr    = sel_tbl ? (tbl_base + tbl_off) : (root + dir_off);

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top #(
   parameter int ADDR_W        = 32,
   parameter int OFFS_W        = 12,
   parameter int IDX_W         = 10,
   parameter int VALID_BIT     = 0,
   parameter int WRITE_BIT     = 1,
   parameter int SIZE_BIT      = 7,
   parameter bit LARGE_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] root_base,
   input  logic              large_en,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   output logic              req_ready,
   output logic              mem_rd_valid,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_rd_ack,
   input  logic [ADDR_W-1:0] mem_rd_data,
   output logic              done_valid,
   output logic [ADDR_W-1:0] done_paddr,
   output logic              done_fault,
   output logic              done_fault_kind,
   output logic              done_fault_level,
   output logic              done_large
);
   import pgwalk_pkg::*;

   localparam int HUGE_LSB = OFFS_W + IDX_W;

   generate
      if (ADDR_W != OFFS_W + 2 * IDX_W) begin : g_bad_split
         $error("pgwalk_top: ADDR_W must equal OFFS_W + 2*IDX_W");
      end
      if (VALID_BIT >= OFFS_W || WRITE_BIT >= OFFS_W || SIZE_BIT >= OFFS_W) begin : g_bad_bits
         $error("pgwalk_top: attribute bits must lie below the frame field");
      end
      if (VALID_BIT == WRITE_BIT || VALID_BIT == SIZE_BIT || WRITE_BIT == SIZE_BIT) begin : g_bad_overlap
         $error("pgwalk_top: attribute bits must be distinct");
      end
   endgenerate

   walk_state_e       state_q;
   logic [ADDR_W-1:0] va_q;
   logic [ADDR_W-1:0] root_q;
   logic [ADDR_W-1:0] tbase_q;
   logic [ADDR_W-1:0] paddr_q;
   logic              wr_q;
   logic              large_q;
   logic              fkind_q;
   logic              flevel_q;
   logic              hit_large_q;

   logic              ent_present;
   logic              ent_denied;
   logic              ent_huge;
   logic [ADDR_W-1:0] ent_small_base;
   logic [ADDR_W-1:0] ent_huge_base;
   logic [ADDR_W-1:0] va_small_off;
   logic [ADDR_W-1:0] va_huge_off;

   pgwalk_pte_dec #(
      .ENTRY_W      (ADDR_W),
      .FRAME_LSB    (OFFS_W),
      .HUGE_LSB     (HUGE_LSB),
      .VALID_BIT    (VALID_BIT),
      .WRITE_BIT    (WRITE_BIT),
      .SIZE_BIT     (SIZE_BIT),
      .LARGE_SUPPORT(LARGE_SUPPORT)
   ) u_dec (
      .entry       (mem_rd_data),
      .large_en    (large_q),
      .is_write    (wr_q),
      .present     (ent_present),
      .write_denied(ent_denied),
      .huge        (ent_huge),
      .small_base  (ent_small_base),
      .huge_base   (ent_huge_base)
   );

   pgwalk_addr #(
      .ADDR_W(ADDR_W),
      .OFFS_W(OFFS_W),
      .IDX_W (IDX_W)
   ) u_addr (
      .sel_tbl (state_q == WS_TBL),
      .root    (root_q),
      .tbl_base(tbase_q),
      .va      (va_q),
      .rd_addr (mem_rd_addr)
   );

   assign va_small_off = {{(ADDR_W-OFFS_W){1'b0}}, va_q[OFFS_W-1:0]};
   assign va_huge_off  = {{(ADDR_W-HUGE_LSB){1'b0}}, va_q[HUGE_LSB-1:0]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= WS_IDLE;
         va_q        <= '0;
         root_q      <= '0;
         tbase_q     <= '0;
         paddr_q     <= '0;
         wr_q        <= 1'b0;
         large_q     <= 1'b0;
         fkind_q     <= FK_ABSENT;
         flevel_q    <= LVL_DIR;
         hit_large_q <= 1'b0;
      end else begin
         unique case (state_q)
            WS_IDLE: begin
               if (req_valid) begin
                  va_q        <= req_addr;
                  wr_q        <= req_write;
                  root_q      <= root_base;
                  large_q     <= large_en;
                  paddr_q     <= '0;
                  fkind_q     <= FK_ABSENT;
                  flevel_q    <= LVL_DIR;
                  hit_large_q <= 1'b0;
                  state_q     <= WS_DIR;
               end
            end
            WS_DIR: begin
               if (mem_rd_ack) begin
                  if (!ent_present) begin
                     fkind_q  <= FK_ABSENT;
                     flevel_q <= LVL_DIR;
                     state_q  <= WS_FAULT;
                  end else if (ent_huge) begin
                     hit_large_q <= 1'b1;
                     if (ent_denied) begin
                        fkind_q  <= FK_PROTECT;
                        flevel_q <= LVL_DIR;
                        state_q  <= WS_FAULT;
                     end else begin
                        paddr_q <= ent_huge_base | va_huge_off;
                        state_q <= WS_DONE;
                     end
                  end else begin
                     tbase_q <= ent_small_base;
                     state_q <= WS_TBL;
                  end
               end
            end
            WS_TBL: begin
               if (mem_rd_ack) begin
                  flevel_q <= LVL_TBL;
                  if (!ent_present) begin
                     fkind_q <= FK_ABSENT;
                     state_q <= WS_FAULT;
                  end else if (ent_denied) begin
                     fkind_q <= FK_PROTECT;
                     state_q <= WS_FAULT;
                  end else begin
                     paddr_q <= ent_small_base | va_small_off;
                     state_q <= WS_DONE;
                  end
               end
            end
            default: state_q <= WS_IDLE;
         endcase
      end
   end

   assign req_ready        = (state_q == WS_IDLE);
   assign mem_rd_valid     = (state_q == WS_DIR) || (state_q == WS_TBL);
   assign done_valid       = (state_q == WS_DONE) || (state_q == WS_FAULT);
   assign done_fault       = (state_q == WS_FAULT);
   assign done_paddr       = paddr_q;
   assign done_fault_kind  = fkind_q;
   assign done_fault_level = flevel_q;
   assign done_large       = hit_large_q;

endmodule

// File: rtl/pgwalk_checker.sv
module pgwalk_checker #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic              req_ready,
   input logic              mem_rd_valid,
   input logic [ADDR_W-1:0] mem_rd_addr,
   input logic              mem_rd_ack,
   input logic              done_valid,
   input logic              done_fault,
   input logic              done_fault_kind,
   input logic              done_fault_level,
   input logic              done_large
);

   logic wr_seen;

   always_ff @(posedge clk) begin
      if (!rst_n) wr_seen <= 1'b0;
      else if (req_valid && req_ready) wr_seen <= req_write;
   end

   assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid |-> !req_ready);

   assert_addr_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_valid && !mem_rd_ack) |=> (mem_rd_valid && $stable(mem_rd_addr)));

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> (!done_valid && req_ready));

   assert_result_no_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> !mem_rd_valid);

   assert_large_one_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && done_large && done_fault) |-> (done_fault_level == 1'b0));

   assert_protect_needs_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && done_fault && done_fault_kind) |-> wr_seen);

endmodule

bind pgwalk_top pgwalk_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .req_valid       (req_valid),
   .req_write       (req_write),
   .req_ready       (req_ready),
   .mem_rd_valid    (mem_rd_valid),
   .mem_rd_addr     (mem_rd_addr),
   .mem_rd_ack      (mem_rd_ack),
   .done_valid      (done_valid),
   .done_fault      (done_fault),
   .done_fault_kind (done_fault_kind),
   .done_fault_level(done_fault_level),
   .done_large      (done_large)
);

// File: tb/pgwalk_top_test.sv
module pgwalk_top_test;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] ROOT = 32'h0010_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] root_base = ROOT;
   logic        large_en = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        req_write = 1'b0;
   logic        req_ready;
   logic        mem_rd_valid;
   logic [31:0] mem_rd_addr;
   logic        mem_rd_ack = 1'b0;
   logic [31:0] mem_rd_data = '0;
   logic        done_valid;
   logic [31:0] done_paddr;
   logic        done_fault;
   logic        done_fault_kind;
   logic        done_fault_level;
   logic        done_large;

   int checks = 0;
   int errors = 0;
   int lat = 0;
   int wait_cnt = 0;
   int rd_cnt = 0;
   logic [31:0] rd_log [0:3];
   logic [31:0] mem [logic [31:0]];

   logic [31:0] r_paddr;
   logic        r_fault, r_kind, r_level, r_large;

   always #(CLK_PERIOD/2) clk = ~clk;

   pgwalk_top uut (
      .clk(clk), .rst_n(rst_n), .root_base(root_base), .large_en(large_en),
      .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
      .req_ready(req_ready), .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
      .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data), .done_valid(done_valid),
      .done_paddr(done_paddr), .done_fault(done_fault), .done_fault_kind(done_fault_kind),
      .done_fault_level(done_fault_level), .done_large(done_large)
   );

   // memory model: answers pending reads after lat idle cycles
   always @(negedge clk) begin
      if (mem_rd_ack) begin
         mem_rd_ack = 1'b0;
      end else if (mem_rd_valid) begin
         if (wait_cnt >= lat) begin
            mem_rd_ack  = 1'b1;
            mem_rd_data = mem.exists(mem_rd_addr) ? mem[mem_rd_addr] : 32'h0;
            if (rd_cnt < 4) rd_log[rd_cnt] = mem_rd_addr;
            rd_cnt++;
            wait_cnt = 0;
         end else begin
            wait_cnt++;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] dir_addr(input logic [31:0] va);
      return ROOT + {20'h0, va[31:22], 2'b00};
   endfunction

   function automatic logic [31:0] tbl_addr(input logic [31:0] pde, input logic [31:0] va);
      return {pde[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
   endfunction

   // drives one request; if stray is set a second request is held during the walk
   task automatic walk(input logic [31:0] va, input logic wr, input bit stray);
      int guard = 0;
      @(negedge clk);
      req_valid = 1'b1; req_addr = va; req_write = wr; rd_cnt = 0; wait_cnt = 0;
      @(negedge clk);
      if (stray) begin
         req_addr = ~va; req_write = ~wr;
      end else begin
         req_valid = 1'b0;
      end
      while (!done_valid && guard < 200) begin
         @(negedge clk);
         guard++;
      end
      req_valid = 1'b0;
      r_paddr = done_paddr; r_fault = done_fault; r_kind = done_fault_kind;
      r_level = done_fault_level; r_large = done_large;
      chk(done_valid, "R8 walk completes", {31'h0, done_valid}, 32'h1);
      @(negedge clk);
      chk(!done_valid && req_ready, "R10 one-cycle result then ready",
          {30'h0, done_valid, req_ready}, 32'h1);
   endtask

   task automatic test_reset();
      chk(req_ready && !mem_rd_valid && !done_valid, "R1 idle after reset",
          {29'h0, req_ready, mem_rd_valid, done_valid}, 32'h4);
   endtask

   task automatic test_small(input int latency);
      logic [31:0] va = 32'h1234_5678;
      logic [31:0] pde = 32'h0020_0003;
      logic [31:0] pte = 32'hABCD_E003;
      mem.delete(); lat = latency; large_en = 1'b1;
      mem[dir_addr(va)] = pde;
      mem[tbl_addr(pde, va)] = pte;
      walk(va, 1'b1, 1'b0);
      chk(rd_cnt == 2, "R3 two reads", rd_cnt, 2);
      chk(rd_log[0] == dir_addr(va), "R2 directory address", rd_log[0], dir_addr(va));
      chk(rd_log[1] == tbl_addr(pde, va), "R3 table address", rd_log[1], tbl_addr(pde, va));
      chk(!r_fault && !r_large, "R3 no fault small page", {30'h0, r_fault, r_large}, 32'h0);
      chk(r_paddr == {pte[31:12], va[11:0]}, "R3 physical address", r_paddr, {pte[31:12], va[11:0]});
   endtask

   task automatic test_large();
      logic [31:0] va = 32'h8765_4321;
      logic [31:0] pde = 32'h0C00_0083;
      mem.delete(); lat = 1; large_en = 1'b1;
      mem[dir_addr(va)] = pde;
      walk(va, 1'b1, 1'b0);
      chk(rd_cnt == 1, "R4 single read", rd_cnt, 1);
      chk(!r_fault && r_large, "R4 large flag", {30'h0, r_fault, r_large}, 32'h1);
      chk(r_paddr == {pde[31:22], va[21:0]}, "R4 physical address", r_paddr, {pde[31:22], va[21:0]});
   endtask

   task automatic test_large_off();
      logic [31:0] va = 32'h8765_4321;
      logic [31:0] pde = 32'h0C00_0083;
      logic [31:0] pte = 32'h5555_6001;
      mem.delete(); lat = 0; large_en = 1'b0;
      mem[dir_addr(va)] = pde;
      mem[tbl_addr(pde, va)] = pte;
      walk(va, 1'b0, 1'b0);
      chk(rd_cnt == 2, "R5 two reads when disabled", rd_cnt, 2);
      chk(rd_log[1] == tbl_addr(pde, va), "R5 table address", rd_log[1], tbl_addr(pde, va));
      chk(!r_large && !r_fault, "R5 no large result", {30'h0, r_fault, r_large}, 32'h0);
      chk(r_paddr == {pte[31:12], va[11:0]}, "R5 physical address", r_paddr, {pte[31:12], va[11:0]});
      large_en = 1'b1;
   endtask

   task automatic test_absent();
      logic [31:0] va = 32'h0040_1ABC;
      logic [31:0] pde = 32'h0030_0001;
      mem.delete(); lat = 2;
      walk(va, 1'b0, 1'b0);
      chk(r_fault && r_kind == 1'b0 && r_level == 1'b0 && rd_cnt == 1, "R6 directory absent",
          {28'h0, r_fault, r_kind, r_level, rd_cnt[0]}, 32'h9);
      mem[dir_addr(va)] = pde;
      walk(va, 1'b0, 1'b0);
      chk(r_fault && r_kind == 1'b0 && r_level == 1'b1 && rd_cnt == 2, "R6 table absent",
          {28'h0, r_fault, r_kind, r_level, rd_cnt[1]}, 32'hB);
   endtask

   task automatic test_protect();
      logic [31:0] va = 32'h0080_2010;
      logic [31:0] pde = 32'h0040_0003;
      logic [31:0] pte = 32'h0077_7001;
      logic [31:0] lva = 32'hC000_0FF0;
      logic [31:0] lpde = 32'h0800_0081;
      mem.delete(); lat = 0; large_en = 1'b1;
      mem[dir_addr(va)] = pde;
      mem[tbl_addr(pde, va)] = pte;
      mem[dir_addr(lva)] = lpde;
      walk(va, 1'b1, 1'b0);
      chk(r_fault && r_kind && r_level, "R7 read-only table write",
          {29'h0, r_fault, r_kind, r_level}, 32'h7);
      walk(va, 1'b0, 1'b0);
      chk(!r_fault && r_paddr == {pte[31:12], va[11:0]}, "R7 read of read-only page",
          r_paddr, {pte[31:12], va[11:0]});
      walk(lva, 1'b1, 1'b0);
      chk(r_fault && r_kind && !r_level && rd_cnt == 1, "R7 read-only large write",
          {28'h0, r_fault, r_kind, r_level, rd_cnt[0]}, 32'hD);
   endtask

   task automatic test_busy_request();
      logic [31:0] va = 32'h1234_5678;
      logic [31:0] pde = 32'h0020_0003;
      logic [31:0] pte = 32'h0BAD_0003;
      mem.delete(); lat = 5; large_en = 1'b1;
      mem[dir_addr(va)] = pde;
      mem[tbl_addr(pde, va)] = pte;
      walk(va, 1'b0, 1'b1);
      chk(rd_cnt == 2 && rd_log[0] == dir_addr(va), "R9 stray request ignored", rd_log[0], dir_addr(va));
      chk(r_paddr == {pte[31:12], va[11:0]} && !r_fault, "R9 result of first request",
          r_paddr, {pte[31:12], va[11:0]});
      chk(rd_cnt == 2, "R9 no extra walk", rd_cnt, 2);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_small(0);
      test_small(4);
      test_large();
      test_large_off();
      test_absent();
      test_protect();
      test_busy_request();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule